// File: doc/BRIEF.md
# Prescaled Periodic Interrupt Timer

This block is a down-counting interval timer with one interrupt line, driven through a small 16-bit register bus. It holds three registers: a control word, a modulus, and a live count that can only be read. Count ticks come from the block clock divided by two and then by a power of two that software picks with a 4-bit exponent. The divisor therefore runs from 2 to 65536 clock cycles per tick.

On every tick while enabled, the count drops by one. The tick that finds the count at zero is the expiry. On expiry the block raises a sticky flag and restarts the count. The restart value is either the modulus (reload mode) or all ones (free-running mode), so a modulus of N gives a period of N+1 ticks. A modulus write always drops the flag. When the overwrite option is on, a modulus write also loads the new value into the count straight away.

A control write that only touches the interrupt enable, or only clears the flag, leaves the count and prescaler phase alone. Any other control write restarts the prescaler phase under the new settings. This lets software acknowledge interrupts without disturbing the timing.

Top module: `pit_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and `irq` is low.
- R2: Registers sit at byte offsets 0 (control), 2 (modulus) and 4 (count). The control bits are: enable bit 0, reload mode bit 1, flag bit 2, interrupt enable bit 3, overwrite bit 4, two stored-only bits 5 and 6, and the exponent in bits 11:8. All other control bits read 0. Writes to offset 4 change nothing, and unused offsets read 0.
- R3: With exponent P, a tick occurs every 2^(P+1) clock cycles. The first decrement lands 2^(P+1) cycles after the control write that restarts the prescaler.
- R4: While enabled, each tick that is not an expiry lowers the count by exactly one.
- R5: In reload mode (bit 1 = 1), the tick that finds the count at 0 loads the modulus, so a modulus of N gives an N+1 tick period.
- R6: In free-running mode (bit 1 = 0), the tick that finds the count at 0 loads 0xFFFF.
- R7: Expiry sets the flag. Writing 1 to control bit 2 clears it, writing 0 there leaves it as it was, and a bus write can never set it.
- R8: `irq` is high exactly when both the flag and the interrupt enable are set.
- R9: Any modulus write clears the flag. With overwrite on, the count takes the written value in the same write cycle. With overwrite off, the count is untouched and the new modulus applies at the next reload.
- R10: A control write that changes only the interrupt enable and/or clears the flag neither reloads the count nor shifts the tick phase.
- R11: Any other control write resets the prescaler phase. The count keeps its value, and ticks then follow the new exponent and mode.
- R12: While the enable bit is 0, no tick occurs and the count holds, except for an overwrite load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (twice the count base rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps the exponent over its low values and also tests the largest one. It samples the count one cycle before and exactly on each expected decrement, so a divider off by one or missing the halving shows up at once. Reload and wrap sequences are checked against an arithmetic model of the count, cycle by cycle. That model catches a period of N instead of N+1 and a reload to the wrong value. Interrupt-only writes land between ticks and are checked against the same model, so a design that wrongly restarts the prescaler drifts in phase and fails. Flag handling is tested for write-zero keeps, write-one clears, a modulus write clears, and set-after-clear, since a design that writes the flag straight from the bus would raise false interrupts.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int BUS_W  = 16;
  localparam int PRE_W  = 4;
  localparam int DIV_W  = 1 << PRE_W;

  // Control bit positions; software and the bench decode these.
  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_DBG  = 5;
  localparam int B_DOZE = 6;
  localparam int B_PRE  = 8;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_MOD  = 3'd2;
  localparam logic [2:0] OFS_CNT  = 3'd4;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ie;
    logic             flag;
    logic             rld;
    logic             en;
  } pit_ctrl_t;

  // Last prescaler state before a tick: 2^(pre+1) - 1.
  function automatic logic [DIV_W-1:0] div_last(input logic [PRE_W-1:0] pre);
    logic [DIV_W-1:0] ones;
    ones = '1;
    return ones >> (DIV_W - 1 - int'(pre));
  endfunction

  function automatic logic [BUS_W-1:0] ctrl_pack(input pit_ctrl_t c);
    logic [BUS_W-1:0] v;
    v = '0;
    v[B_EN]   = c.en;
    v[B_RLD]  = c.rld;
    v[B_FLAG] = c.flag;
    v[B_IE]   = c.ie;
    v[B_OVW]  = c.ovw;
    v[B_DBG]  = c.dbg;
    v[B_DOZE] = c.doze;
    v[B_PRE +: PRE_W] = c.pre;
    return v;
  endfunction

  // Flag is never taken from the bus; caller supplies the kept value.
  function automatic pit_ctrl_t ctrl_unpack(input logic [BUS_W-1:0] v,
                                            input logic kept_flag);
    pit_ctrl_t c;
    c.en   = v[B_EN];
    c.rld  = v[B_RLD];
    c.flag = kept_flag;
    c.ie   = v[B_IE];
    c.ovw  = v[B_OVW];
    c.dbg  = v[B_DBG];
    c.doze = v[B_DOZE];
    c.pre  = v[B_PRE +: PRE_W];
    return c;
  endfunction

  // True when a new control value differs in anything beyond IE and flag.
  function automatic logic cfg_differs(input pit_ctrl_t a, input pit_ctrl_t b);
    return (a.en != b.en) || (a.rld != b.rld) || (a.ovw != b.ovw) ||
           (a.dbg != b.dbg) || (a.doze != b.doze) || (a.pre != b.pre);
  endfunction

endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  logic [DIV_W-1:0] div_q;
  logic             at_last;

  assign at_last = (div_q == div_last(pre));
  assign tick    = run && at_last && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (restart) begin
      div_q <= '0;
    end else if (run) begin
      if (at_last) div_q <= '0;
      else         div_q <= div_q + 1'b1;
    end
  end

endmodule

// File: rtl/pit_downcount.sv
module pit_downcount #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload_mode,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic [CNT_W-1:0] restart_val;

  assign expire      = tick && (count == '0) && !load_en;
  assign restart_val = reload_mode ? modulus : ALL_ONES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= ALL_ONES;
    end else if (load_en) begin
      count <= load_val;
    end else if (expire) begin
      count <= restart_val;
    end else if (tick) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             expire,
  output pit_ctrl_t        ctrl,
  output logic [CNT_W-1:0] modulus,
  output logic             cfg_restart,
  output logic             mod_wr,
  output logic             mod_load,
  output logic             flag_clr,
  output logic             irq
);

  logic      ctrl_wr;
  pit_ctrl_t ctrl_new;

  assign ctrl_wr     = wr_en && (addr == OFS_CTRL);
  assign mod_wr      = wr_en && (addr == OFS_MOD);
  assign ctrl_new    = ctrl_unpack(wdata, ctrl.flag);
  assign cfg_restart = ctrl_wr && cfg_differs(ctrl_new, ctrl);
  assign mod_load    = mod_wr && ctrl.ovw;
  assign flag_clr    = (ctrl_wr && wdata[B_FLAG]) || mod_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_new;
      // expiry wins over a clear landing on the same edge
      ctrl.flag <= (ctrl.flag && !flag_clr) || expire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      modulus <= '1;
    else if (mod_wr) modulus <= CNT_W'(wdata);
  end

  assign irq = ctrl.flag && ctrl.ie;

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             irq
);

  pit_ctrl_t        ctrl;
  logic [CNT_W-1:0] modulus;
  logic [CNT_W-1:0] count;
  logic             cfg_restart;
  logic             mod_wr;
  logic             mod_load;
  logic             flag_clr;
  logic             tick;
  logic             expire;

  pit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .expire     (expire),
    .ctrl       (ctrl),
    .modulus    (modulus),
    .cfg_restart(cfg_restart),
    .mod_wr     (mod_wr),
    .mod_load   (mod_load),
    .flag_clr   (flag_clr),
    .irq        (irq)
  );

  pit_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrl.en),
    .restart(cfg_restart),
    .pre    (ctrl.pre),
    .tick   (tick)
  );

  pit_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load_en    (mod_load),
    .load_val   (CNT_W'(bus_wdata)),
    .reload_mode(ctrl.rld),
    .modulus    (modulus),
    .count      (count),
    .expire     (expire)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_pack(ctrl);
      OFS_MOD:  bus_rdata = BUS_W'(modulus);
      OFS_CNT:  bus_rdata = BUS_W'(count);
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             expire,
  input logic             mod_wr,
  input logic             mod_load,
  input logic             enable,
  input logic             reload,
  input logic             flag,
  input logic             irq,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] modulus
);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !expire && !mod_load) |=> count == CNT_W'($past(count) - 1'b1));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && reload) |=> count == $past(modulus));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !reload) |=> count == {CNT_W{1'b1}});

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  assert_irq_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  assert_mod_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && !expire) |=> !flag);

  assert_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !mod_load) |=> $stable(count));

  assert_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick);

endmodule

bind pit_timer pit_checker #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .expire  (expire),
  .mod_wr  (mod_wr),
  .mod_load(mod_load),
  .enable  (ctrl.en),
  .reload  (ctrl.rld),
  .flag    (ctrl.flag),
  .irq     (irq),
  .count   (count),
  .modulus (modulus)
);

// File: tb/tb_pit_timer.sv
`timescale 1ns/1ps
module tb_pit_timer;

  localparam int EN = 1, RLD = 2, FLG = 4, IE = 8, OVW = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int t_ref  = 0;

  pit_timer dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 0;
    t_ref = cyc;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wait_to(input int e);
    while (cyc - t_ref < e) @(negedge clk);
  endtask

  function automatic int model(input int s, input int n, input int t);
    if (t <= s) return s - t;
    return n - ((t - s - 1) % (n + 1));
  endfunction

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, c0, d, base;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 0);
    rd(2, v); check("R1 modulus", v, 16'hFFFF);
    rd(4, v); check("R1 count", v, 16'hFFFF);
    check("R1 irq", int'(irq), 0);

    // R2 field layout, reserved bits, unused offset
    wr(0, 16'hFFFF);
    rd(0, v); check("R2 ctrl readback", v, 16'h0F7B);
    wr(0, 0);
    rd(0, v); check("R2 ctrl cleared", v, 0);
    rd(6, v); check("R2 unused offset", v, 0);

    // R9 modulus write without overwrite leaves count
    wr(2, 16'h1234);
    rd(2, v); check("R9 modulus", v, 16'h1234);
    rd(4, v); check("R9 no load", v, 16'hFFFF);
    // R2 write to count ignored
    wr(4, 0);
    rd(4, v); check("R2 count write ignored", v, 16'hFFFF);
    rd(2, v); check("R2 modulus untouched", v, 16'h1234);

    // R3/R4 exponent sweep, sample just before and on each third tick
    for (int p = 0; p <= 6; p++) begin
      wr(0, EN | (p << 8));
      rd(4, c0);
      d = 2 << p;
      wait_to(3 * d - 1);
      rd(4, v); check("R3 before tick", v, c0 - 2);
      wait_to(3 * d);
      rd(4, v); check("R4 on tick", v, c0 - 3);
    end

    // R12 disable freezes
    wr(0, 6 << 8);
    rd(4, c0);
    wait_to(500);
    rd(4, v); check("R12 frozen", v, c0);

    // R3 largest exponent
    wr(0, EN | (15 << 8));
    rd(4, c0);
    wait_to(65535);
    rd(4, v); check("R3 pre15 before", v, c0);
    wait_to(65536);
    rd(4, v); check("R3 pre15 tick", v, c0 - 1);
    wr(0, 0);

    // R5/R7/R8/R10 reload mode, modulus 3, D=4
    wr(0, OVW);
    wr(2, 3);
    rd(4, v); check("R9 overwrite load", v, 3);
    wr(0, EN | RLD | OVW | (1 << 8));
    base = t_ref;
    for (int e = 1; e <= 17; e++) begin
      wait_to(e);
      rd(4, v); check("R5 reload sequence", v, model(3, 3, e / 4));
      if (e == 15) begin rd(0, v); check("R7 flag before expiry", (v >> 2) & 1, 0); end
      if (e == 16) begin
        rd(0, v); check("R7 flag on expiry", (v >> 2) & 1, 1);
        check("R8 irq masked", int'(irq), 0);
      end
    end
    wait_to(18);
    wr(0, EN | RLD | OVW | IE | (1 << 8));
    t_ref = base;
    rd(0, v); check("R7 write 0 keeps flag", (v >> 2) & 1, 1);
    check("R8 irq raised", int'(irq), 1);
    for (int e = 20; e <= 36; e++) begin
      wait_to(e);
      rd(4, v); check("R10 IE write keeps phase", v, model(3, 3, e / 4));
    end
    wr(0, EN | RLD | OVW | IE | FLG | (1 << 8));
    t_ref = base;
    rd(0, v); check("R7 write 1 clears", (v >> 2) & 1, 0);
    check("R8 irq dropped", int'(irq), 0);
    for (int e = 39; e <= 48; e++) begin
      wait_to(e);
      rd(4, v); check("R10 clear write keeps phase", v, model(3, 3, e / 4));
    end
    rd(0, v); check("R7 flag set again", (v >> 2) & 1, 1);
    check("R8 irq again", int'(irq), 1);

    // R11 exponent change restarts phase, count kept
    wait_to(50);
    wr(0, EN | RLD | OVW | IE);
    rd(4, v); check("R11 count kept", v, model(3, 3, 12));
    wait_to(1);
    rd(4, v); check("R11 before new tick", v, 3);
    wait_to(2);
    rd(4, v); check("R11 new tick", v, 2);
    wr(2, 3);
    rd(0, v); check("R9 modulus write clears flag", (v >> 2) & 1, 0);
    check("R9 irq after clear", int'(irq), 0);
    rd(4, v); check("R9 overwrite load while running", v, 3);
    wr(0, 0);

    // R6 free-running wrap
    wr(0, OVW);
    wr(2, 2);
    wr(0, EN | OVW);
    wait_to(5);
    rd(4, v); check("R6 at zero", v, 0);
    wait_to(6);
    rd(4, v); check("R6 wrap", v, 16'hFFFF);
    rd(0, v); check("R7 flag on wrap", (v >> 2) & 1, 1);
    wait_to(8);
    rd(4, v); check("R6 after wrap", v, 16'hFFFE);
    wr(0, 0);

    // R9 new modulus taken at next reload without overwrite
    wr(0, OVW);
    wr(2, 1);
    wr(0, RLD);
    wr(2, 5);
    rd(4, v); check("R9 count untouched", v, 1);
    rd(0, v); check("R9 flag cleared", (v >> 2) & 1, 0);
    wr(0, EN | RLD);
    wait_to(2);
    rd(4, v); check("R5 reaches zero", v, 0);
    wait_to(4);
    rd(4, v); check("R5 new modulus reload", v, 5);
    wr(0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule